// File: doc/BRIEF.md
# Fuse and Protection-Bit Controller

This block holds the protection state and the configuration fuses of a small programmable controller. A two-bit protection field decides whether the flash and EEPROM arrays may be written or read back. A fuse byte is held twice. A stored copy takes the values that programming commands write. An active copy drives the rest of the chip and only picks up the stored values when a power-on reset ends. Every bit of both fields is unprogrammed at 1 and programmed at 0.

Programming-mode commands arrive as a one-cycle strobe with an opcode and a data field. There are four opcodes: protection write, fuse write, chip erase and one reserved code. Each command is answered one cycle later by a done pulse and an accepted flag. A chip erase also emits erase pulses toward the flash array and, unless the fuses say otherwise, the EEPROM array. Memory write and read requests are granted or refused combinationally from the protection state. A refused read returns all ones.

Two resets are used. `cold_n` stands for the first power-up of the nonvolatile cells. `rst_n` is the ordinary power-on reset pulse. Both are asynchronous and active low, and each must be released synchronously to `clk`.

Top module: `cfg_guard`

## Requirements
- R1: While `cold_n` is low, `lock_state` becomes 2'b11 and the stored fuses become all ones. While `rst_n` is low, `fuse_active` is all ones and `cmd_done`, `cmd_ok`, `flash_erase` and `eeprom_erase` are 0.
- R2: Bit 0 of `lock_state` is the first protection bit and bit 1 is the second. A memory write is granted only when `lock_state` is 2'b11. A read is granted unless `lock_state` is 2'b00. For each memory, `mem_rd_data_o` passes `mem_rd_data_i` when reads are permitted and is all ones otherwise.
- R3: Opcode 0 (protection write) sets `lock_state` to its old value ANDed with `cmd_data[1:0]` and is always accepted. A 1 in the data never raises a bit.
- R4: Opcode 2 (chip erase) is always accepted. It returns `lock_state` to 2'b11, pulses `flash_erase` for one cycle together with `cmd_done`, and leaves the stored fuses unchanged.
- R5: During a chip erase, `eeprom_erase` pulses only when active fuse bit PRESERVE_BIT is 1. When that bit is 0 (programmed), the EEPROM is kept.
- R6: Opcode 1 (fuse write) is accepted when `lock_state` is 2'b11. It replaces the stored fuses with `cmd_data`, including bits that return from 0 to 1.
- R7: A fuse write while `lock_state` is not 2'b11 is rejected and leaves the stored fuses unchanged.
- R8: `fuse_active` takes the stored fuse value on the first clock after `rst_n` is released and then holds until the next `rst_n` pulse.
- R9: Every command produces `cmd_done` high for one cycle, one clock after the strobe, with `cmd_ok` giving the verdict. Opcode 3 is rejected and has no effect.
- R10: A pulse on `rst_n` alone changes neither `lock_state` nor the stored fuses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_n | input | 1 | First power-up reset of the nonvolatile bits, active low |
| rst_n | input | 1 | Power-on reset pulse, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 protection write, 1 fuse write, 2 chip erase, 3 reserved |
| cmd_data | input | FUSE_W | Protection bits in [1:0] or new fuse value |
| cmd_done | output | 1 | Command answered, one cycle |
| cmd_ok | output | 1 | Command accepted, valid with cmd_done |
| flash_erase | output | 1 | Flash erase pulse |
| eeprom_erase | output | 1 | EEPROM erase pulse |
| lock_state | output | 2 | Current protection bits |
| fuse_active | output | FUSE_W | Fuse values in force |
| mem_wr_req | input | NMEM | Write request per memory |
| mem_rd_req | input | NMEM | Read request per memory |
| mem_rd_data_i | input | NMEM*DATA_W | Read data from the arrays |
| mem_wr_gnt | output | NMEM | Write grant per memory |
| mem_rd_gnt | output | NMEM | Read grant per memory |
| mem_rd_data_o | output | NMEM*DATA_W | Read data after protection |

## Verification
The bench uses the defaults: FUSE_W=8, NMEM=2, DATA_W=8 and PRESERVE_BIT=3. With two memories, each with its own request lines, the bench can show that gating acts on every array independently under random request mixes. An eight-bit fuse field lets a single write both program the preserve bit and return other bits to 1. This covers the EEPROM-kept and EEPROM-erased outcomes of a chip erase, and fuse values that only appear after a reset pulse.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  typedef enum logic [1:0] {
    OP_LOCK  = 2'd0,
    OP_FUSE  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } cmd_op_e;

  localparam logic [1:0] PROT_OPEN = 2'b11;
endpackage

// File: rtl/cfg_guard_lock.sv
module cfg_guard_lock
  import cfg_guard_pkg::*;
(
  input  logic       clk,
  input  logic       cold_n,
  input  logic       wr_en,
  input  logic [1:0] wr_bits,
  input  logic       erase,
  output logic [1:0] lock_q,
  output logic       wr_allow,
  output logic       rd_allow
);
  logic [1:0] lock_d;
  logic       lock_en;

  always_comb begin
    lock_en = wr_en | erase;
    lock_d  = lock_q;
    if (erase)      lock_d = PROT_OPEN;
    else if (wr_en) lock_d = lock_q & wr_bits;
  end

  always_ff @(posedge clk or negedge cold_n) begin
    if (!cold_n)      lock_q <= PROT_OPEN;
    else if (lock_en) lock_q <= lock_d;
  end

  assign wr_allow = &lock_q;
  assign rd_allow = |lock_q;
endmodule

// File: rtl/cfg_guard_fuse.sv
module cfg_guard_fuse #(
  parameter int FUSE_W = 8
) (
  input  logic              clk,
  input  logic              cold_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FUSE_W-1:0] wr_val,
  output logic [FUSE_W-1:0] active_q
);
  logic [FUSE_W-1:0] stored_q, stored_d;
  logic              loaded_q;
  logic [FUSE_W-1:0] active_d;
  logic              active_en;

  always_comb begin
    stored_d  = wr_val;
    active_d  = stored_q;
    active_en = ~loaded_q;
  end

  always_ff @(posedge clk or negedge cold_n) begin
    if (!cold_n)    stored_q <= '1;
    else if (wr_en) stored_q <= stored_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '1;
      loaded_q <= 1'b0;
    end else if (active_en) begin
      active_q <= active_d;
      loaded_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_guard_gate.sv
module cfg_guard_gate #(
  parameter int DATA_W = 8
) (
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rd_in,
  input  logic              wr_allow,
  input  logic              rd_allow,
  output logic              wr_gnt,
  output logic              rd_gnt,
  output logic [DATA_W-1:0] rd_out
);
  always_comb begin
    wr_gnt = wr_req & wr_allow;
    rd_gnt = rd_req & rd_allow;
    rd_out = rd_allow ? rd_in : '1;
  end
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int FUSE_W       = 8,
  parameter int NMEM         = 2,
  parameter int DATA_W       = 8,
  parameter int PRESERVE_BIT = 3
) (
  input  logic                     clk,
  input  logic                     cold_n,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [FUSE_W-1:0]        cmd_data,
  output logic                     cmd_done,
  output logic                     cmd_ok,
  output logic                     flash_erase,
  output logic                     eeprom_erase,
  output logic [1:0]               lock_state,
  output logic [FUSE_W-1:0]        fuse_active,
  input  logic [NMEM-1:0]          mem_wr_req,
  input  logic [NMEM-1:0]          mem_rd_req,
  input  logic [NMEM*DATA_W-1:0]   mem_rd_data_i,
  output logic [NMEM-1:0]          mem_wr_gnt,
  output logic [NMEM-1:0]          mem_rd_gnt,
  output logic [NMEM*DATA_W-1:0]   mem_rd_data_o
);
  localparam int PB = (PRESERVE_BIT < FUSE_W) ? PRESERVE_BIT : FUSE_W - 1;

  cmd_op_e op;
  logic    prot_wr, fuse_wr, erase;
  logic    wr_allow, rd_allow;
  logic    done_d, ok_d, fe_d, ee_d;

  always_comb begin
    op      = cmd_op_e'(cmd_op);
    prot_wr = 1'b0;
    fuse_wr = 1'b0;
    erase   = 1'b0;
    ok_d    = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_LOCK:  begin prot_wr = 1'b1; ok_d = 1'b1; end
        OP_FUSE:  begin fuse_wr = wr_allow; ok_d = wr_allow; end
        OP_ERASE: begin erase = 1'b1; ok_d = 1'b1; end
        default:  ok_d = 1'b0;
      endcase
    end
    done_d = cmd_valid;
    fe_d   = erase;
    ee_d   = erase & fuse_active[PB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_done     <= 1'b0;
      cmd_ok       <= 1'b0;
      flash_erase  <= 1'b0;
      eeprom_erase <= 1'b0;
    end else begin
      cmd_done     <= done_d;
      cmd_ok       <= ok_d;
      flash_erase  <= fe_d;
      eeprom_erase <= ee_d;
    end
  end

  cfg_guard_lock u_lock (
    .clk      (clk),
    .cold_n   (cold_n),
    .wr_en    (prot_wr),
    .wr_bits  (cmd_data[1:0]),
    .erase    (erase),
    .lock_q   (lock_state),
    .wr_allow (wr_allow),
    .rd_allow (rd_allow)
  );

  cfg_guard_fuse #(.FUSE_W(FUSE_W)) u_fuse (
    .clk      (clk),
    .cold_n   (cold_n),
    .rst_n    (rst_n),
    .wr_en    (fuse_wr),
    .wr_val   (cmd_data),
    .active_q (fuse_active)
  );

  for (genvar g = 0; g < NMEM; g++) begin : g_mem
    cfg_guard_gate #(.DATA_W(DATA_W)) u_gate (
      .wr_req   (mem_wr_req[g]),
      .rd_req   (mem_rd_req[g]),
      .rd_in    (mem_rd_data_i[g*DATA_W +: DATA_W]),
      .wr_allow (wr_allow),
      .rd_allow (rd_allow),
      .wr_gnt   (mem_wr_gnt[g]),
      .rd_gnt   (mem_rd_gnt[g]),
      .rd_out   (mem_rd_data_o[g*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int FUSE_W = 8,
  parameter int NMEM   = 2,
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   cold_n,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic [1:0]             cmd_op,
  input logic                   cmd_done,
  input logic                   cmd_ok,
  input logic                   flash_erase,
  input logic                   eeprom_erase,
  input logic [1:0]             lock_state,
  input logic [FUSE_W-1:0]      fuse_active,
  input logic [NMEM-1:0]        mem_wr_gnt,
  input logic [NMEM-1:0]        mem_rd_gnt,
  input logic [NMEM*DATA_W-1:0] mem_rd_data_o
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  a_r2_wr_blocked: assert property (@(posedge clk) disable iff (!cold_n)
    (lock_state != 2'b11) |-> (mem_wr_gnt == '0));

  a_r2_rd_blocked: assert property (@(posedge clk) disable iff (!cold_n)
    (lock_state == 2'b00) |-> ((mem_rd_gnt == '0) && (&mem_rd_data_o)));

  a_r3_one_way: assert property (@(posedge clk) disable iff (!cold_n || !rst_n)
    (|(lock_state & ~$past(lock_state))) |-> $past(cmd_valid && cmd_op == 2'd2));

  a_r4_erase_opens: assert property (@(posedge clk) disable iff (!cold_n || !rst_n)
    (cmd_valid && cmd_op == 2'd2) |=> (lock_state == 2'b11 && flash_erase && cmd_ok));

  a_r5_ee_with_flash: assert property (@(posedge clk) disable iff (!rst_n)
    eeprom_erase |-> flash_erase);

  a_r7_fuse_refused: assert property (@(posedge clk) disable iff (!cold_n || !rst_n)
    (cmd_valid && cmd_op == 2'd1 && lock_state != 2'b11) |=> (cmd_done && !cmd_ok));

  a_r8_fuse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> $stable(fuse_active));

  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> cmd_done);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !cmd_done);
endmodule

bind cfg_guard cfg_guard_chk #(
  .FUSE_W (FUSE_W),
  .NMEM   (NMEM),
  .DATA_W (DATA_W)
) chk_i (
  .clk           (clk),
  .cold_n        (cold_n),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .cmd_done      (cmd_done),
  .cmd_ok        (cmd_ok),
  .flash_erase   (flash_erase),
  .eeprom_erase  (eeprom_erase),
  .lock_state    (lock_state),
  .fuse_active   (fuse_active),
  .mem_wr_gnt    (mem_wr_gnt),
  .mem_rd_gnt    (mem_rd_gnt),
  .mem_rd_data_o (mem_rd_data_o)
);

// File: tb/cfg_guard_tb_top.sv
`timescale 1ns/1ps
module cfg_guard_tb_top;
  localparam int FW = 8;
  localparam int NM = 2;
  localparam int DW = 8;
  localparam int PB = 3;

  logic clk = 1'b0;
  logic cold_n = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [FW-1:0] cmd_data = '0;
  logic cmd_done, cmd_ok, flash_erase, eeprom_erase;
  logic [1:0] lock_state;
  logic [FW-1:0] fuse_active;
  logic [NM-1:0] mem_wr_req = '0, mem_rd_req = '0;
  logic [NM*DW-1:0] mem_rd_data_i = '0;
  logic [NM-1:0] mem_wr_gnt, mem_rd_gnt;
  logic [NM*DW-1:0] mem_rd_data_o;

  always #2 clk = ~clk;

  cfg_guard #(.FUSE_W(FW), .NMEM(NM), .DATA_W(DW), .PRESERVE_BIT(PB)) dut_i (
    .clk(clk), .cold_n(cold_n), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_done(cmd_done), .cmd_ok(cmd_ok),
    .flash_erase(flash_erase), .eeprom_erase(eeprom_erase),
    .lock_state(lock_state), .fuse_active(fuse_active),
    .mem_wr_req(mem_wr_req), .mem_rd_req(mem_rd_req),
    .mem_rd_data_i(mem_rd_data_i), .mem_wr_gnt(mem_wr_gnt),
    .mem_rd_gnt(mem_rd_gnt), .mem_rd_data_o(mem_rd_data_o)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [1:0]    m_lock;
  logic [FW-1:0] m_st, m_act;
  bit m_ld, m_done, m_ok, m_fe, m_ee;

  always @(posedge clk or negedge rst_n or negedge cold_n) begin
    if (!cold_n) begin m_lock = 2'b11; m_st = '1; end
    if (!rst_n) begin
      m_act = '1; m_ld = 0; m_done = 0; m_ok = 0; m_fe = 0; m_ee = 0;
    end
    if (cold_n && rst_n) begin
      logic [1:0] l0;
      logic [FW-1:0] s0;
      l0 = m_lock; s0 = m_st;
      m_done = cmd_valid; m_ok = 0; m_fe = 0; m_ee = 0;
      if (cmd_valid) begin
        case (cmd_op)
          2'd0: begin m_ok = 1; m_lock = l0 & cmd_data[1:0]; end
          2'd1: begin m_ok = (l0 == 2'b11); if (m_ok) m_st = cmd_data; end
          2'd2: begin m_ok = 1; m_lock = 2'b11; m_fe = 1; m_ee = m_act[PB]; end
          default: m_ok = 0;
        endcase
      end
      if (!m_ld) begin m_act = s0; m_ld = 1; end
    end
  end

  // per-clock comparison, away from the active edge
  always begin
    @(negedge clk);
    #1;
    chk("R3", "lock_state", 32'(lock_state), 32'(m_lock));
    chk("R8", "fuse_active", 32'(fuse_active), 32'(m_act));
    chk("R9", "cmd_done", 32'(cmd_done), 32'(m_done));
    if (m_done) chk("R9", "cmd_ok", 32'(cmd_ok), 32'(m_ok));
    chk("R4", "flash_erase", 32'(flash_erase), 32'(m_fe));
    chk("R5", "eeprom_erase", 32'(eeprom_erase), 32'(m_ee));
    for (int i = 0; i < NM; i++) begin
      logic [DW-1:0] ed;
      ed = (m_lock != 2'b00) ? mem_rd_data_i[i*DW +: DW] : '1;
      chk("R2", "wr_gnt", 32'(mem_wr_gnt[i]), 32'(mem_wr_req[i] && m_lock == 2'b11));
      chk("R2", "rd_gnt", 32'(mem_rd_gnt[i]), 32'(mem_rd_req[i] && m_lock != 2'b00));
      chk("R2", "rd_data", 32'(mem_rd_data_o[i*DW +: DW]), 32'(ed));
    end
  end

  task automatic cmd(input logic [1:0] op, input logic [FW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_data = '0;
  endtask

  task automatic por_pulse();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic traffic(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      mem_wr_req = NM'($urandom);
      mem_rd_req = NM'($urandom);
      mem_rd_data_i = (NM*DW)'({$urandom, $urandom});
    end
    @(negedge clk);
    mem_wr_req = '0; mem_rd_req = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset fuse_active", 32'(fuse_active), 32'hFF);
    chk("R1", "reset cmd_done", 32'(cmd_done), 32'd0);
    @(negedge clk); cold_n = 1'b1; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "cold lock_state", 32'(lock_state), 32'h3);
    chk("R1", "cold fuses loaded", 32'(fuse_active), 32'hFF);
    traffic(20);

    cmd(2'd1, 8'h00);                    // R6 program every fuse
    #1 chk("R8", "new fuse not yet active", 32'(fuse_active), 32'hFF);
    por_pulse();
    chk("R6", "fuses after reset", 32'(fuse_active), 32'h00);
    cmd(2'd1, 8'hF7);                    // R6 bits return to 1, preserve programmed
    por_pulse();
    chk("R6", "fuses back to 1", 32'(fuse_active), 32'hF7);

    cmd(2'd0, 8'h02);                    // mode 2: first bit programmed
    traffic(20);
    cmd(2'd1, 8'h55);                    // R7 refused
    cmd(2'd0, 8'h03);                    // R3 attempt to raise
    #1 chk("R3", "no raise", 32'(lock_state), 32'h2);
    por_pulse();
    chk("R7", "fuses unchanged", 32'(fuse_active), 32'hF7);
    chk("R10", "lock kept over reset", 32'(lock_state), 32'h2);

    cmd(2'd0, 8'h00);                    // mode 3
    traffic(20);
    cmd(2'd3, 8'hA5);                    // R9 reserved opcode
    cmd(2'd2, 8'h00);                    // erase, EEPROM kept (R5)
    #1 chk("R4", "erase opens", 32'(lock_state), 32'h3);
    por_pulse();
    chk("R4", "erase keeps fuses", 32'(fuse_active), 32'hF7);

    cmd(2'd1, 8'hFF);
    por_pulse();
    cmd(2'd2, 8'h00);                    // erase, EEPROM erased (R5)
    cmd(2'd0, 8'h01);                    // second bit only: writes blocked
    traffic(20);
    cmd(2'd1, 8'h00);                    // R7 refused
    cmd(2'd2, 8'h00);
    traffic(10);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule